// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled by watching the up and down pulses that come out of its phase-frequency detector. Both pulses are sampled on a fast clock. A reference strobe marks the end of each reference period. In each period the block counts the fast-clock cycles in which the two pulses disagree. A period counts as good when that count stays inside a selectable error window. The lock flag rises only after a programmable run of good periods in a row.

Two modes are available. In continuous mode every period is judged, and a single bad period drops the flag and restarts the qualification run. In one-shot mode the flag stays high after the first lock until the loop is disabled. A status-select input places either the lock flag or an external RSSI-low flag on one shared status bit. A status-word reader can take that bit as bit 11 of its read-only word.

Top module: `pll_lock_monitor`

## Requirements
- R1: The mismatch of a reference period is the number of fast-clock cycles in which `pfd_up` and `pfd_dn` differ. A cycle with both high or both low adds nothing. A period ends with, and includes, the cycle in which `ref_tick` is high. The next period starts on the following cycle.
- R2: A period is good when its mismatch is at most the narrow window (3 cycles) with `cfg_wide_win`=0, or at most the wide window (6 cycles) with `cfg_wide_win`=1. A larger mismatch makes the period bad.
- R3: `cfg_qual_sel` sets the number of consecutive good periods needed for lock: 0→2, 1→4, 2→8, 3→16. `lock_flag` is high from the cycle after the clock edge that samples the `ref_tick` of the qualifying period.
- R4: With `cfg_oneshot`=0, a bad period clears `lock_flag` at the edge that samples its `ref_tick`. It also restarts the qualification run, so the full number of good periods is needed again.
- R5: With `cfg_oneshot`=1, once `lock_flag` is high it stays high whatever the mismatch of later periods, until `pll_en` falls or reset.
- R6: `stat_bit` equals `lock_flag` when `cfg_stat_sel`=0 and equals `rssi_low` when `cfg_stat_sel`=1, with no clock delay.
- R7: After a synchronous `rst`, or in any cycle where `pll_en` is low, the next cycle shows `lock_flag` low. The mismatch count and the qualification run are then both cleared.
- R8: The per-period mismatch count saturates, so a long mismatch can never wrap around into a good period (for example 258 mismatch cycles in one period is bad).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_en | input | 1 | Loop enable; low clears lock state |
| ref_tick | input | 1 | High for one cycle at the last cycle of each reference period |
| pfd_up | input | 1 | Detector up pulse |
| pfd_dn | input | 1 | Detector down pulse |
| cfg_qual_sel | input | 2 | Qualification length select (2/4/8/16 periods) |
| cfg_wide_win | input | 1 | 0: narrow error window, 1: wide error window |
| cfg_oneshot | input | 1 | 0: continuous checking, 1: hold after first lock |
| cfg_stat_sel | input | 1 | 0: status bit shows lock, 1: shows RSSI-low |
| rssi_low | input | 1 | External RSSI-low flag |
| lock_flag | output | 1 | Lock-detect flag |
| stat_bit | output | 1 | Shared status bit |

## Verification
A mismatch accumulator that keeps its count across the period boundary, or that wraps, turns a bad period into a good one or the reverse. The lock flag then rises a reference period early, or falls where it should hold, on the very next strobe edge. A wrong qualification count moves the rising edge of `lock_flag` away from the exact expected period. The bench sweeps every length, window and mode and checks the flag after every period, so such an error shows up within one period of its cause. A latch that is wrong in one-shot mode shows as the flag falling on the first bad period after lock.

// File: rtl/pll_ld_pkg.sv
package pll_ld_pkg;

    // Width of the per-period mismatch accumulator (saturating).
    localparam int unsigned MISM_CNT_W = 8;
    // Longest qualification run and the counter width that holds it.
    localparam int unsigned QUAL_MAX   = 16;
    localparam int unsigned QCNT_W     = $clog2(QUAL_MAX + 1);

    typedef enum logic [1:0] {
        QUAL_2  = 2'd0,
        QUAL_4  = 2'd1,
        QUAL_8  = 2'd2,
        QUAL_16 = 2'd3
    } qual_sel_e;

    typedef struct packed {
        logic                  valid;   // a reference period ends this cycle
        logic [MISM_CNT_W-1:0] count;   // disagreeing cycles in that period
    } period_res_t;

    function automatic logic [QCNT_W-1:0] qual_periods(input qual_sel_e sel);
        logic [QCNT_W-1:0] n;
        n = QCNT_W'(2) << sel;
        return n;
    endfunction

    function automatic logic [MISM_CNT_W-1:0] sat_inc(
        input logic [MISM_CNT_W-1:0] v,
        input logic                  inc
    );
        logic [MISM_CNT_W-1:0] r;
        if (inc && (v != {MISM_CNT_W{1'b1}})) r = v + MISM_CNT_W'(1);
        else                                  r = v;
        return r;
    endfunction

endpackage

// File: rtl/pll_ld_mismatch_meter.sv
module pll_ld_mismatch_meter
    import pll_ld_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        tick,
    input  logic        up,
    input  logic        dn,
    output period_res_t res
);

    logic [MISM_CNT_W-1:0] acc_q;
    logic [MISM_CNT_W-1:0] sum;

    // Current cycle is part of the period that the tick closes.
    assign sum       = sat_inc(acc_q, up ^ dn);
    assign res.valid = en & tick;
    assign res.count = sum;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum;
        end
    end

endmodule

// File: rtl/pll_ld_qualifier.sv
module pll_ld_qualifier
    import pll_ld_pkg::*;
#(
    parameter int unsigned NARROW_WIN = 3,
    parameter int unsigned WIDE_WIN   = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  period_res_t res,
    input  logic        wide_win,
    input  qual_sel_e   qual_sel,
    input  logic        oneshot,
    output logic        lock
);

    localparam logic [MISM_CNT_W-1:0] WIN_N = MISM_CNT_W'(NARROW_WIN);
    localparam logic [MISM_CNT_W-1:0] WIN_W = MISM_CNT_W'(WIDE_WIN);

    logic [QCNT_W-1:0]     qcnt_q;
    logic [QCNT_W-1:0]     qcnt_inc;
    logic [MISM_CNT_W-1:0] win;
    logic                  good;
    logic                  frozen;

    assign win      = wide_win ? WIN_W : WIN_N;
    assign good     = (res.count <= win);
    assign frozen   = oneshot & lock;
    assign qcnt_inc = (qcnt_q == {QCNT_W{1'b1}}) ? qcnt_q : qcnt_q + QCNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            qcnt_q <= '0;
            lock   <= 1'b0;
        end else if (res.valid && !frozen) begin
            if (good) begin
                qcnt_q <= qcnt_inc;
                lock   <= (qcnt_inc >= qual_periods(qual_sel));
            end else begin
                qcnt_q <= '0;
                lock   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pll_ld_status_mux.sv
module pll_ld_status_mux (
    input  logic sel,
    input  logic lock,
    input  logic rssi_low,
    output logic stat
);

    always_comb begin
        stat = sel ? rssi_low : lock;
    end

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
    import pll_ld_pkg::*;
#(
    parameter int unsigned NARROW_WIN = 3,
    parameter int unsigned WIDE_WIN   = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pll_en,
    input  logic       ref_tick,
    input  logic       pfd_up,
    input  logic       pfd_dn,
    input  logic [1:0] cfg_qual_sel,
    input  logic       cfg_wide_win,
    input  logic       cfg_oneshot,
    input  logic       cfg_stat_sel,
    input  logic       rssi_low,
    output logic       lock_flag,
    output logic       stat_bit
);

    period_res_t res;

    pll_ld_mismatch_meter u_meter (
        .clk  (clk),
        .rst  (rst),
        .en   (pll_en),
        .tick (ref_tick),
        .up   (pfd_up),
        .dn   (pfd_dn),
        .res  (res)
    );

    pll_ld_qualifier #(
        .NARROW_WIN (NARROW_WIN),
        .WIDE_WIN   (WIDE_WIN)
    ) u_qual (
        .clk      (clk),
        .rst      (rst),
        .en       (pll_en),
        .res      (res),
        .wide_win (cfg_wide_win),
        .qual_sel (qual_sel_e'(cfg_qual_sel)),
        .oneshot  (cfg_oneshot),
        .lock     (lock_flag)
    );

    pll_ld_status_mux u_stat (
        .sel      (cfg_stat_sel),
        .lock     (lock_flag),
        .rssi_low (rssi_low),
        .stat     (stat_bit)
    );

endmodule

// File: rtl/pll_lock_monitor_chk.sv
module pll_lock_monitor_chk (
    input logic clk,
    input logic rst,
    input logic pll_en,
    input logic ref_tick,
    input logic cfg_oneshot,
    input logic cfg_stat_sel,
    input logic rssi_low,
    input logic lock_flag,
    input logic stat_bit
);

    // R7: a disabled loop shows no lock in the next cycle
    p_low_when_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        !pll_en |=> !lock_flag);

    // R3: lock can only rise on the edge that samples a reference strobe
    p_rise_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_flag) |-> $past(ref_tick));

    // R4: while enabled, the flag only changes at a period boundary
    p_change_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        (!$stable(lock_flag) && $past(pll_en)) |-> $past(ref_tick));

    // R5: in one-shot mode a held lock survives while enabled
    p_oneshot_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (lock_flag && cfg_oneshot && pll_en) |=> lock_flag);

    // R6: with select high the status bit shows the RSSI flag
    p_stat_rssi_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_stat_sel |-> (stat_bit == rssi_low));

endmodule

bind pll_lock_monitor pll_lock_monitor_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .pll_en       (pll_en),
    .ref_tick     (ref_tick),
    .cfg_oneshot  (cfg_oneshot),
    .cfg_stat_sel (cfg_stat_sel),
    .rssi_low     (rssi_low),
    .lock_flag    (lock_flag),
    .stat_bit     (stat_bit)
);

// File: tb/test_pll_lock_monitor.sv
module test_pll_lock_monitor;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pll_en = 1'b0;
    logic       ref_tick = 1'b0;
    logic       pfd_up = 1'b0;
    logic       pfd_dn = 1'b0;
    logic [1:0] cfg_qual_sel = 2'd3;
    logic       cfg_wide_win = 1'b0;
    logic       cfg_oneshot = 1'b0;
    logic       cfg_stat_sel = 1'b0;
    logic       rssi_low = 1'b0;
    logic       lock_flag;
    logic       stat_bit;

    int checks = 0;
    int fails  = 0;
    int m_q    = 0;
    bit m_lock = 1'b0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pll_lock_monitor i_pll_lock_monitor (
        .clk          (clk),
        .rst          (rst),
        .pll_en       (pll_en),
        .ref_tick     (ref_tick),
        .pfd_up       (pfd_up),
        .pfd_dn       (pfd_dn),
        .cfg_qual_sel (cfg_qual_sel),
        .cfg_wide_win (cfg_wide_win),
        .cfg_oneshot  (cfg_oneshot),
        .cfg_stat_sel (cfg_stat_sel),
        .rssi_low     (rssi_low),
        .lock_flag    (lock_flag),
        .stat_bit     (stat_bit)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // Bench model of one reference period result (R2..R5).
    task automatic model_period(input int mism);
        int win;
        int tgt;
        win = cfg_wide_win ? 6 : 3;
        tgt = 2 << cfg_qual_sel;
        if (!(cfg_oneshot && m_lock)) begin
            if (mism <= win) begin
                m_q++;
                m_lock = (m_q >= tgt);
            end else begin
                m_q = 0;
                m_lock = 1'b0;
            end
        end
    endtask

    // One period: n_up up-only cycles, n_dn down-only, n_both both high,
    // rest idle; the last cycle carries the strobe (R1).
    task automatic period(input int len, input int n_up, input int n_dn, input int n_both);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            pfd_up   = (i < n_up) || (i >= n_up + n_dn && i < n_up + n_dn + n_both);
            pfd_dn   = (i >= n_up && i < n_up + n_dn + n_both);
            ref_tick = (i == len - 1);
        end
        @(negedge clk);
        ref_tick = 1'b0;
        pfd_up   = 1'b0;
        pfd_dn   = 1'b0;
        model_period(n_up + n_dn);
    endtask

    task automatic disable_loop();
        @(negedge clk);
        pll_en = 1'b0;
        @(negedge clk);
        check("R7 disabled", lock_flag, 1'b0);
        pll_en = 1'b1;
        m_q = 0;
        m_lock = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset", lock_flag, 1'b0);
        rst = 1'b0;
        pll_en = 1'b1;

        // Sweep every qualification length, window and mode.
        for (int q = 0; q < 4; q++) begin
            for (int w = 0; w < 2; w++) begin
                for (int os = 0; os < 2; os++) begin
                    @(negedge clk);
                    cfg_qual_sel = 2'(q);
                    cfg_wide_win = 1'(w);
                    cfg_oneshot  = 1'(os);
                    disable_loop();
                    for (int p = 0; p < (2 << q) + 5; p++) begin
                        int win;
                        win = w ? 6 : 3;
                        if (p == (2 << q)) begin
                            // one cycle past the window: bad (R2, R4, R5)
                            period(20, win + 1 - win / 2, win / 2, 2);
                            check(os ? "R5 hold on bad" : "R4 clear on bad", lock_flag, m_lock);
                        end else begin
                            // exactly on the window edge, mixed up/dn (R1, R2, R3)
                            period(20, win - win / 2, win / 2, 3);
                            check("R3 qualify", lock_flag, m_lock);
                        end
                    end
                end
            end
        end

        // R4: a bad period in the middle of a run restarts the full count.
        @(negedge clk);
        cfg_qual_sel = 2'd1; cfg_wide_win = 1'b0; cfg_oneshot = 1'b0;
        disable_loop();
        period(12, 1, 1, 0); period(12, 2, 0, 0); period(12, 0, 3, 0);
        check("R4 mid-run", lock_flag, m_lock);
        period(12, 4, 0, 0);
        check("R4 bad clears count", lock_flag, m_lock);
        for (int p = 0; p < 4; p++) begin
            period(12, 0, 0, 5);
            check("R4 requalify", lock_flag, m_lock);
        end

        // R8: 258 mismatch cycles must be bad even on the wide window.
        cfg_wide_win = 1'b1;
        period(300, 258, 0, 0);
        check("R8 saturate", lock_flag, m_lock);
        check("R8 saturate bad", lock_flag, 1'b0);

        // R7: disabling mid-period clears accumulated mismatch.
        period(10, 0, 0, 0); period(10, 0, 0, 0);
        period(10, 0, 0, 0); period(10, 0, 0, 0);
        check("R7 locked before disable", lock_flag, 1'b1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); pfd_up = 1'b1;
        end
        pfd_up = 1'b0;
        disable_loop();
        period(10, 4, 0, 0);
        check("R7 count cleared", lock_flag, m_lock);

        // R6: status select sweep.
        for (int s = 0; s < 2; s++) begin
            for (int r = 0; r < 2; r++) begin
                @(negedge clk);
                cfg_stat_sel = 1'(s);
                rssi_low = 1'(r);
                #1;
                check("R6 status mux", stat_bit, s ? 1'(r) : lock_flag);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule